// File: doc/BRIEF.md
# Stretchable External Memory Cycle Controller

This block runs a single read or write cycle on an external data memory bus. The cycle length is set by a 3-bit stretch value, so the same bus can reach fast memories and slow peripherals. A request carries a direction flag, a 16-bit address and, for writes, a data byte. The controller then drives an address-valid qualifier, a read strobe or a write strobe, and the write data. For a read it captures the returned byte. It marks the end of each cycle with a one-clock completion pulse.

The stretch value is taken from the three least significant bits of an 8-bit clock-control register inside the block. Software writes and reads this register through a simple port. The upper five bits are storage only. The register's stretch field is latched when a request is accepted, so the timing of a cycle is fixed for its whole length.

The controller has six states:
- `ST_IDLE` waits for a request.
- `ST_READ` holds the address and the read strobe.
- `ST_WSETUP` is the first write cycle: address and data are out, with no strobe yet.
- `ST_WPULSE` holds the write strobe.
- `ST_WHOLD` is the final write cycle: address and data are still out, and the strobe is off.
- `ST_FINISH` pulses completion.

The transitions are:
- `ST_IDLE` goes to `ST_READ` on a read request and to `ST_WSETUP` on a write request.
- `ST_READ` goes to `ST_FINISH` when its width count runs out.
- `ST_WSETUP` always goes to `ST_WPULSE`.
- `ST_WPULSE` goes to `ST_WHOLD` when its count runs out and stretch is nonzero, and straight to `ST_FINISH` when stretch is zero.
- `ST_WHOLD` always goes to `ST_FINISH`.
- `ST_FINISH` always goes back to `ST_IDLE`.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: The clock-control register resets to 0x01, so the stretch value S is 1. A write stores all eight bits, and `cfg_rdata` returns the stored value. S is bits 2..0 of the register.
- R2: In a read cycle, `mem_addr_vld` is high for exactly S+1 consecutive clocks. `mem_addr` stays constant while it is high.
- R3: In a read cycle, `mem_rd` is high for exactly S+1 clocks, the same clocks in which `mem_addr_vld` is high.
- R4: In a write cycle, `mem_addr_vld` is high for exactly S+2 consecutive clocks.
- R5: In a write cycle, `mem_wr` is high for 1 clock when S is 0 and for S clocks when S is 1..7. It always rises in the second address-valid clock.
- R6: `rd_data` takes the value of `mem_rdata` present in the last clock of the read strobe. It keeps that value until the next read.
- R7: `done` is high for exactly one clock, the clock just after `mem_addr_vld` falls. `busy` is high from the clock after acceptance through the `done` clock.
- R8: `mem_wdata` equals the request's write data in every address-valid clock of a write cycle, and is zero at all other times.
- R9: `mem_rd` and `mem_wr` are never high together, and neither is high while `mem_addr_vld` is low.
- R10: A request is accepted only when `busy` is low. A request raised while busy is ignored, and no extra cycle follows.
- R11: Bits 7..3 of the clock-control register have no effect on cycle timing.
- R12: A register write during a cycle does not change that cycle's timing. It applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Clock-control register write enable |
| cfg_wdata | input | 8 | Clock-control register write value |
| cfg_rdata | output | 8 | Clock-control register contents |
| req | input | 1 | Start a cycle (sampled while idle) |
| req_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A cycle is in progress |
| mem_addr | output | 16 | Address to memory |
| mem_addr_vld | output | 1 | Address valid qualifier |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_wdata | output | 8 | Write data to memory |
| mem_rdata | input | 8 | Read data from memory |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench walks all eight stretch values for both directions and counts every strobe and qualifier width in clocks. An off-by-one in the width counter, or swapping the read and write formulas, shows up as a wrong count in a single row. Stretch 0 on a write is the special case: a design that used the plain S formula there would produce a zero-width write strobe. The read-data source changes every strobe clock, so capturing one clock early or late is seen as a wrong byte. Further tests write the configuration register in the middle of a cycle, raise a request while busy, and set the upper register bits. A design that re-reads the stretch field during a cycle, restarts while busy, or decodes more than three bits would change a width or add a cycle.

// File: rtl/xms_pkg.sv
package xms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_FINISH
    } xms_state_e;

endpackage

// File: rtl/xms_cfg_reg.sv
module xms_cfg_reg #(
    parameter int CFG_W = 8,
    parameter int STR_W = 3,
    parameter logic [CFG_W-1:0] RST_VAL = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic [STR_W-1:0] stretch
);

    logic [CFG_W-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RST_VAL;
        end else if (we) begin
            reg_q <= wdata;
        end
    end

    assign rdata   = reg_q;
    assign stretch = reg_q[STR_W-1:0];

endmodule

// File: rtl/xms_width_cnt.sv
module xms_width_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/xms_datapath.sv
module xms_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wdata_en,
    input  logic              rd_capture,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (latch_req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_capture) begin
            rdata_q <= mem_rdata;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_en ? wdata_q : '0;
    assign rd_data   = rdata_q;

endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl
    import xms_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CFG_W  = 8,
    parameter int STR_W  = 3,
    parameter logic [CFG_W-1:0] CFG_RST = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_addr_vld,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    localparam logic [STR_W-1:0] STR_ZERO = '0;
    localparam logic [STR_W-1:0] STR_ONE  = STR_W'(1);

    xms_state_e       state_q, state_d;
    logic [STR_W-1:0] cfg_stretch;
    logic [STR_W-1:0] stretch_q;
    logic             accept;
    logic             cnt_load;
    logic [STR_W-1:0] cnt_load_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             rd_capture;
    logic             wdata_en;

    xms_cfg_reg #(
        .CFG_W   (CFG_W),
        .STR_W   (STR_W),
        .RST_VAL (CFG_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .stretch (cfg_stretch)
    );

    assign accept = (state_q == ST_IDLE) && req;

    // stretch frozen for the whole cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stretch_q <= STR_ONE;
        end else if (accept) begin
            stretch_q <= cfg_stretch;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = req_wr ? ST_WSETUP : ST_READ;
                end
            end
            ST_READ: begin
                if (cnt_zero) state_d = ST_FINISH;
            end
            ST_WSETUP: state_d = ST_WPULSE;
            ST_WPULSE: begin
                if (cnt_zero) begin
                    state_d = (stretch_q == STR_ZERO) ? ST_FINISH : ST_WHOLD;
                end
            end
            ST_WHOLD:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and counter control
    always_comb begin
        busy         = 1'b1;
        mem_addr_vld = 1'b0;
        mem_rd       = 1'b0;
        mem_wr       = 1'b0;
        done         = 1'b0;
        wdata_en     = 1'b0;
        rd_capture   = 1'b0;
        cnt_load     = 1'b0;
        cnt_load_val = STR_ZERO;
        cnt_dec      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy         = 1'b0;
                cnt_load     = req && !req_wr;
                cnt_load_val = cfg_stretch;
            end
            ST_READ: begin
                mem_addr_vld = 1'b1;
                mem_rd       = 1'b1;
                cnt_dec      = 1'b1;
                rd_capture   = cnt_zero;
            end
            ST_WSETUP: begin
                mem_addr_vld = 1'b1;
                wdata_en     = 1'b1;
                cnt_load     = 1'b1;
                cnt_load_val = (stretch_q == STR_ZERO) ? STR_ZERO
                                                       : stretch_q - STR_ONE;
            end
            ST_WPULSE: begin
                mem_addr_vld = 1'b1;
                mem_wr       = 1'b1;
                wdata_en     = 1'b1;
                cnt_dec      = 1'b1;
            end
            ST_WHOLD: begin
                mem_addr_vld = 1'b1;
                wdata_en     = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    xms_width_cnt #(
        .W (STR_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    xms_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_req  (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .wdata_en   (wdata_en),
        .rd_capture (rd_capture),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/xms_stretch_chk.sv
module xms_stretch_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_addr_vld,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              done
);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_rd_in_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr_vld);

    assert_wr_in_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr_vld);

    assert_done_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_addr_vld && $past(mem_addr_vld)));

    assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> mem_addr_vld);

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr_vld && $past(mem_addr_vld)) |-> $stable(mem_addr));

    assert_wdata_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_addr_vld |-> (mem_wdata == '0));

    assert_wr_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $past(mem_addr_vld));

endmodule

bind xmem_stretch_ctrl xms_stretch_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .busy         (busy),
    .mem_addr     (mem_addr),
    .mem_addr_vld (mem_addr_vld),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_wdata    (mem_wdata),
    .done         (done)
);

// File: tb/xmem_stretch_ctrl_tb.sv
module xmem_stretch_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy;
    logic [15:0] mem_addr;
    logic        mem_addr_vld;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'hFF;
    logic [7:0]  rd_data;
    logic        done;

    int total = 0;
    int bad   = 0;

    // measured by run_cycle
    int a_cnt, r_cnt, w_cnt, w_start, d_cnt, d_at, wd_err, ov_err, ad_err;

    // {direction (1 = write), clock-control value}
    localparam logic [8:0] VEC [0:15] = '{
        9'h000, 9'h001, 9'h002, 9'h003, 9'h0F4, 9'h005, 9'h086, 9'h007,
        9'h100, 9'h101, 9'h1A2, 9'h103, 9'h104, 9'h1F5, 9'h106, 9'h107
    };

    always #10 clk = ~clk;

    xmem_stretch_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .req          (req),
        .req_wr       (req_wr),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .busy         (busy),
        .mem_addr     (mem_addr),
        .mem_addr_vld (mem_addr_vld),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .rd_data      (rd_data),
        .done         (done)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one cycle; optional mid-cycle register write and request while busy
    task automatic run_cycle(input logic wr, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] base,
                             input bit mid_cfg, input logic [7:0] mid_val,
                             input bit poke);
        a_cnt = 0; r_cnt = 0; w_cnt = 0; w_start = 0; d_cnt = 0; d_at = -1;
        wd_err = 0; ov_err = 0; ad_err = 0;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        for (int it = 0; it < 24; it++) begin
            if (mid_cfg && it == 0) begin cfg_we = 1'b1; cfg_wdata = mid_val; end
            if (mid_cfg && it == 1) cfg_we = 1'b0;
            if (poke && it == 1) begin req = 1'b1; req_wr = ~wr; req_addr = ~addr; end
            if (poke && it == 2) req = 1'b0;
            if ((mem_rd && mem_wr) || ((mem_rd || mem_wr) && !mem_addr_vld)) ov_err++;
            if (mem_addr_vld) begin
                a_cnt++;
                if (mem_addr != addr) ad_err++;
                if (wr && mem_wdata != wd) wd_err++;
                if (!wr && mem_wdata != 8'h00) wd_err++;
            end else if (mem_wdata != 8'h00) begin
                wd_err++;
            end
            if (mem_wr) begin
                w_cnt++;
                if (w_start == 0) w_start = a_cnt;
            end
            if (mem_rd) begin
                r_cnt++;
                mem_rdata = base + 8'(r_cnt);
            end else begin
                mem_rdata = 8'hFF;
            end
            if (done) begin
                d_cnt++;
                d_at = it;
                @(negedge clk);
                chk(!done, "R7 done width", int'(done), 0);
                chk(!busy, "R7 busy after done", int'(busy), 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_cycle(input logic wr, input int s, input logic [7:0] base,
                               input logic [7:0] prev_rd, input string tag);
        int exp_a;
        int exp_w;
        exp_a = wr ? s + 2 : s + 1;
        exp_w = (s == 0) ? 1 : s;
        if (wr) begin
            chk(a_cnt == exp_a, {tag, " R4 write addr width"}, a_cnt, exp_a);
            chk(w_cnt == exp_w, {tag, " R5 write strobe width"}, w_cnt, exp_w);
            chk(w_start == 2, {tag, " R5 write strobe start"}, w_start, 2);
            chk(r_cnt == 0, {tag, " R9 no read strobe"}, r_cnt, 0);
            chk(rd_data == prev_rd, {tag, " R6 rd_data held"}, rd_data, prev_rd);
        end else begin
            chk(a_cnt == exp_a, {tag, " R2 read addr width"}, a_cnt, exp_a);
            chk(r_cnt == exp_a, {tag, " R3 read strobe width"}, r_cnt, exp_a);
            chk(w_cnt == 0, {tag, " R9 no write strobe"}, w_cnt, 0);
            chk(rd_data == base + 8'(exp_a), {tag, " R6 read capture"},
                rd_data, base + 8'(exp_a));
        end
        chk(d_cnt == 1 && d_at == exp_a, {tag, " R7 done position"}, d_at, exp_a);
        chk(wd_err == 0, {tag, " R8 write data"}, wd_err, 0);
        chk(ov_err == 0, {tag, " R9 strobe overlap"}, ov_err, 0);
        chk(ad_err == 0, {tag, " R2 address held"}, ad_err, 0);
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] prev_rd;
        repeat (3) @(negedge clk);
        // reset state
        chk(cfg_rdata == 8'h01, "R1 reset value", cfg_rdata, 1);
        chk(!mem_addr_vld && !busy && !done, "R7 idle at reset",
            int'({mem_addr_vld, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // default stretch 1 read before any register write (R1)
        run_cycle(1'b0, 16'h1234, 8'h00, 8'h40, 1'b0, 8'h00, 1'b0);
        check_cycle(1'b0, 1, 8'h40, 8'h00, "default");

        // vector table: every stretch, both directions; upper bits vary (R11)
        for (int i = 0; i < 16; i++) begin
            logic [7:0] cv;
            logic       wr;
            cv = VEC[i][7:0];
            wr = VEC[i][8];
            write_cfg(cv);
            chk(cfg_rdata == cv, "R1 register readback", cfg_rdata, cv);
            prev_rd = rd_data;
            run_cycle(wr, 16'hA000 + 16'(i * 37), 8'h5A ^ 8'(i), 8'(i * 16),
                      1'b0, 8'h00, 1'b0);
            check_cycle(wr, int'(cv[2:0]), 8'(i * 16), prev_rd, $sformatf("vec%0d R11", i));
        end

        // R11: same stretch, all upper bits set vs clear, write direction
        write_cfg(8'hFB);
        prev_rd = rd_data;
        run_cycle(1'b1, 16'h0F0F, 8'hC3, 8'h00, 1'b0, 8'h00, 1'b0);
        check_cycle(1'b1, 3, 8'h00, prev_rd, "R11 upper bits");

        // R12: register write during a read with S=2, new value S=5
        write_cfg(8'h02);
        run_cycle(1'b0, 16'h7777, 8'h00, 8'h10, 1'b1, 8'h05, 1'b0);
        check_cycle(1'b0, 2, 8'h10, 8'h00, "R12 in-flight");
        chk(cfg_rdata == 8'h05, "R12 register updated", cfg_rdata, 5);
        run_cycle(1'b0, 16'h7778, 8'h00, 8'h20, 1'b0, 8'h00, 1'b0);
        check_cycle(1'b0, 5, 8'h20, 8'h00, "R12 next cycle");

        // R10: request while busy is dropped
        write_cfg(8'h03);
        prev_rd = rd_data;
        run_cycle(1'b1, 16'h2222, 8'h99, 8'h00, 1'b0, 8'h00, 1'b1);
        check_cycle(1'b1, 3, 8'h00, prev_rd, "R10 busy request");
        begin
            int extra = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (mem_addr_vld || busy) extra++;
            end
            chk(extra == 0, "R10 no extra cycle", extra, 0);
        end

        // back-to-back: request raised on the first idle cycle
        write_cfg(8'h00);
        run_cycle(1'b1, 16'hFFFF, 8'h01, 8'h00, 1'b0, 8'h00, 1'b0);
        check_cycle(1'b1, 0, 8'h00, rd_data, "R5 min write");
        run_cycle(1'b0, 16'h0000, 8'h00, 8'h30, 1'b0, 8'h00, 1'b0);
        check_cycle(1'b0, 0, 8'h30, 8'h00, "R3 min read");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule